// File: doc/BRIEF.md
# Three-Wire Serial Word Writer

This block is a write-only serial master for a peripheral that takes 16-bit control words over three lines: an active-low frame sync, a serial clock and a serial data line. Each word arrives through a valid/ready handshake. The block lowers the sync while the clock is high and sends the word most significant bit first. Data changes only while the clock is high, and the peripheral samples it on the falling edge. At the end of the frame the clock goes back high, and after a hold interval the sync rises again.

The clock half-period, the data setup time and the sync hold time are all counts of the system clock, set by parameters. No read-back path exists, because the peripheral has no output. The host sends a multi-word setup sequence by handing over one word after another. The block puts a minimum sync-high gap between consecutive frames.

Top module: `sync_word_writer`

## Requirements
- R1: In reset and right after it, `sync_n` and `sclk` are 1, `sdata` is 0, `in_ready` is 1 and `busy` is 0.
- R2: Each frame gives exactly WORD_W (16) falling edges of `sclk` while `sync_n` is 0. The bits sampled on those edges are the accepted word, bit 15 first.
- R3: `sclk` is 1 whenever `sync_n` falls and whenever `sync_n` rises, so the clock idles high outside frames.
- R4: `sdata` changes only while `sclk` is 1, and it holds its value for at least SETUP_CYC system cycles before each falling `sclk` edge.
- R5: Within a frame, every high phase of `sclk` lasts at least max(HALF_CYC, SETUP_CYC) cycles and every low phase lasts at least HALF_CYC cycles.
- R6: After the last falling `sclk` edge of a frame, `sync_n` stays 0 for at least HALF_CYC + HOLD_CYC cycles. This covers the final low phase, the return of the clock to high, and then HOLD_CYC more cycles.
- R7: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `busy` rises on that edge together with the fall of `sync_n`, and it stays 1 until `sync_n` rises. `in_ready` is 0 whenever `busy` is 1.
- R8: Between two frames, `sync_n` stays 1 for at least HALF_CYC cycles.
- R9: While `in_ready` is 0, `in_valid` and `in_word` have no effect. A word offered then and withdrawn before `in_ready` returns is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is offered on `in_word` |
| in_word | input | WORD_W | Word to send |
| in_ready | output | 1 | Block can take a word this cycle |
| busy | output | 1 | A frame is in progress (sync low) |
| sync_n | output | 1 | Frame sync, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, sampled by the peripheral on the falling `sclk` edge |

## Verification
The hardest case to reach from the ports is a word offered while a frame is still shifting. The block must ignore it, and nothing must be sent once the block becomes ready again. The stimulus starts a frame and then keeps `in_valid` high with a different word for several dozen cycles in mid-frame. It withdraws that word before the frame ends and then checks that the number of frames matches the number of accepted words. Back-to-back handovers also exercise the minimum sync-high gap. All timing windows are measured by the monitor from the edges it observes, not taken from the design.

// File: rtl/sww_pkg.sv
// Package: shared types for the three-wire serial word writer.
// Assumes: only the controller decodes the phase encoding.
package sww_pkg;

    // Frame phases of the serial controller
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // waiting for a word, sync and clock high
        PH_HIGH = 3'd1,   // clock high, data bit presented
        PH_LOW  = 3'd2,   // clock low, data held
        PH_TAIL = 3'd3,   // clock high after last bit, sync still low
        PH_GAP  = 3'd4    // sync high, enforced space before next frame
    } phase_e;

endpackage

// File: rtl/phase_timer.sv
// Module: phase_timer
// Down counter that measures the length of one frame phase in system cycles.
// Assumes: load value N gives done_o high N cycles after the load edge;
// the counter rests at zero until it is loaded again.
module phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and rest there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    // R5: once expired, the timer stays expired until reloaded
    timer_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> done_o)
        else $error("timer left zero without a load");

endmodule

// File: rtl/word_shifter.sv
// Module: word_shifter
// Holds the word being sent and presents its current bit, MSB first.
// Assumes: shift_i is only raised while the presented bit is not the last one.
module word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    input  logic              clear_i,
    output logic              msb_o,
    output logic              last_o
);

    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg_q;
    logic [BIT_W-1:0]  idx_q;

    // Shift register: load a word, move it left one bit, or clear to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= word_i;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
        end else if (clear_i) begin
            sreg_q <= '0;
        end
    end

    // Bit index: counts bits already presented in the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= '0;
        end else if (shift_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign msb_o  = sreg_q[WORD_W-1];
    assign last_o = (idx_q == LAST_IDX);

    // R2: never shift beyond the final bit of a word
    shift_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !last_o)
        else $error("shift requested after last bit");

    // R2: the first bit presented is the top bit of the loaded word
    load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (msb_o == $past(word_i[WORD_W-1])))
        else $error("loaded word does not present its MSB");

endmodule

// File: rtl/sync_word_writer.sv
// Module: sync_word_writer (top)
// Write-only three-wire serial master: takes a word by valid/ready and sends
// it MSB first with an idle-high clock, data changing while the clock is high.
// Assumes: HALF_CYC, SETUP_CYC and HOLD_CYC are each at least 1; all outputs
// are driven from flops so the lines change cleanly on system clock edges.
module sync_word_writer #(
    parameter int WORD_W    = 16,
    parameter int HALF_CYC  = 2,
    parameter int SETUP_CYC = 3,
    parameter int HOLD_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              busy,
    output logic              sync_n,
    output logic              sclk,
    output logic              sdata
);
    import sww_pkg::*;

    localparam int HI_CYC  = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
    localparam int MAX_CYC = (HI_CYC > HOLD_CYC) ? HI_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HI_LOAD   = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LOAD   = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

    phase_e           phase_q, phase_d;
    logic             sclk_q, sclk_d;
    logic             sync_q, sync_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_shift, sh_clear, sh_msb, sh_last;
    logic             accept;

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .word_i  (in_word),
        .shift_i (sh_shift),
        .clear_i (sh_clear),
        .msb_o   (sh_msb),
        .last_o  (sh_last)
    );

    assign in_ready = (phase_q == PH_IDLE);
    assign accept   = in_valid && in_ready;

    // Next-phase, line levels and sub-block controls for each frame phase
    always_comb begin
        phase_d  = phase_q;
        sclk_d   = sclk_q;
        sync_d   = sync_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    phase_d  = PH_HIGH;
                    sync_d   = 1'b0;
                    sclk_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = HI_LOAD;
                    sh_load  = 1'b1;
                end
            end
            PH_HIGH: begin
                if (tmr_done) begin
                    phase_d  = PH_LOW;
                    sclk_d   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LO_LOAD;
                end
            end
            PH_LOW: begin
                if (tmr_done) begin
                    sclk_d   = 1'b1;
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        phase_d = PH_TAIL;
                        tmr_val = HOLD_LOAD;
                    end else begin
                        phase_d  = PH_HIGH;
                        tmr_val  = HI_LOAD;
                        sh_shift = 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                if (tmr_done) begin
                    phase_d  = PH_GAP;
                    sync_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LO_LOAD;
                    sh_clear = 1'b1;
                end
            end
            PH_GAP: begin
                if (tmr_done) begin
                    phase_d = PH_IDLE;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                sclk_d  = 1'b1;
                sync_d  = 1'b1;
            end
        endcase
    end

    // Phase and output line registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sclk_q  <= 1'b1;
            sync_q  <= 1'b1;
        end else begin
            phase_q <= phase_d;
            sclk_q  <= sclk_d;
            sync_q  <= sync_d;
        end
    end

    assign busy   = (phase_q == PH_HIGH) || (phase_q == PH_LOW) || (phase_q == PH_TAIL);
    assign sync_n = sync_q;
    assign sclk   = sclk_q;
    assign sdata  = sh_msb;

    // R3
    sync_fall_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_q) |-> sclk_q)
        else $error("sync fell with clock low");

    // R3
    sync_rise_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> sclk_q)
        else $error("sync rose with clock low");

    // R4
    data_still_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_q |-> $stable(sh_msb))
        else $error("data moved while clock low");

    // R7
    ready_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready)
        else $error("ready raised during a frame");

    // R7
    accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !sync_q))
        else $error("accepted word did not start a frame");

endmodule

// File: tb/sync_word_writer_tb.sv
module sync_word_writer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int HALF_CYC   = 2;
    localparam int SETUP_CYC  = 3;
    localparam int HOLD_CYC   = 4;
    localparam int HI_CYC     = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [WORD_W-1:0] in_word = '0;
    logic              in_ready, busy, sync_n, sclk, sdata;

    int n_checks = 0;
    int n_fails  = 0;
    int n_sent   = 0;
    int n_frames = 0;
    logic [WORD_W-1:0] exp_q[$];

    sync_word_writer #(
        .WORD_W(WORD_W), .HALF_CYC(HALF_CYC),
        .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .busy(busy), .sync_n(sync_n), .sclk(sclk), .sdata(sdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Driver: offer a word, push it to the scoreboard once it is accepted
    task automatic send_word(input logic [WORD_W-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(w);
        n_sent++;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // Monitor state
    logic p_sclk = 1'b1, p_sync = 1'b1, p_sdata = 1'b0;
    logic [WORD_W-1:0] got_w = '0;
    int bits = 0, hi_run = 0, lo_run = 0, age = 0, since_fall = 0, gap_run = 0;
    bit in_frame = 0, seen_frame = 0;
    bit bad_hi = 0, bad_lo = 0, bad_setup = 0, bad_busy = 0, bad_move = 0;

    // Monitor: sample lines mid-cycle, measure timing, compare against scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if ((busy !== !sync_n) || (busy && in_ready)) bad_busy = 1;
            if (!sclk && (sdata !== p_sdata)) bad_move = 1;
            if (p_sync && !sync_n) begin
                check(sclk === 1'b1, "R3", "sclk at sync fall", sclk, 1);
                if (seen_frame)
                    check(gap_run >= HALF_CYC, "R8", "sync high gap", gap_run, HALF_CYC);
                in_frame = 1; bits = 0; got_w = '0;
                bad_hi = 0; bad_lo = 0; bad_setup = 0; bad_busy = 0; bad_move = 0;
            end
            if (in_frame && p_sclk && !sclk) begin
                if (hi_run < HI_CYC) bad_hi = 1;
                if (age < SETUP_CYC) bad_setup = 1;
                got_w = {got_w[WORD_W-2:0], sdata};
                bits++;
            end
            if (in_frame && !p_sclk && sclk && lo_run < HALF_CYC) bad_lo = 1;
            if (!p_sync && sync_n && in_frame) begin
                logic [WORD_W-1:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : ~got_w;
                n_frames++;
                check(got_w === e, "R2", "frame word", got_w, e);
                check(bits == WORD_W, "R2", "falling edges", bits, WORD_W);
                check(sclk === 1'b1, "R3", "sclk at sync rise", sclk, 1);
                check(!bad_setup && !bad_move, "R4", "data setup/stability", bad_setup, 0);
                check(!bad_hi && !bad_lo, "R5", "clock phase widths", {bad_hi, bad_lo}, 0);
                check(since_fall + 1 >= HALF_CYC + HOLD_CYC, "R6", "sync hold cycles",
                      since_fall + 1, HALF_CYC + HOLD_CYC);
                check(!bad_busy, "R7", "busy/ready vs sync", bad_busy, 0);
                in_frame = 0; seen_frame = 1;
            end
            if (in_frame && p_sclk && !sclk) since_fall = 0; else since_fall++;
            if (sclk == p_sclk) begin
                if (sclk) hi_run++; else lo_run++;
            end else begin
                hi_run = 1; lo_run = 1;
            end
            if (sdata !== p_sdata) age = 1; else age++;
            if (sync_n && p_sync) gap_run++; else gap_run = 1;
        end
        p_sclk = sclk; p_sync = sync_n; p_sdata = sdata;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: levels while in reset
        check(sync_n === 1'b1 && sclk === 1'b1, "R1", "sync/sclk in reset", {sync_n, sclk}, 3);
        check(sdata === 1'b0 && in_ready === 1'b1 && busy === 1'b0, "R1",
              "sdata/ready/busy in reset", {sdata, in_ready, busy}, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: levels right after reset
        check(sync_n === 1'b1 && sclk === 1'b1 && sdata === 1'b0 && in_ready === 1'b1,
              "R1", "idle after reset", {sync_n, sclk, sdata, in_ready}, 4'b1101);

        send_word(16'h2100);
        send_word(16'h0000);
        send_word(16'hFFFF);
        send_word(16'hA5A5);
        send_word(16'h8001);
        send_word(16'h570A);

        // R9: offer a word mid-frame and withdraw it before ready returns
        send_word(16'h4003);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 16'hDEAD;
        repeat (40) @(negedge clk);
        check(in_ready === 1'b0, "R9", "ready during frame", in_ready, 0);
        in_valid = 1'b0;
        send_word(16'h91B7);

        repeat (200) @(negedge clk);
        check(n_frames == n_sent, "R9", "frames vs accepted words", n_frames, n_sent);
        check(exp_q.size() == 0, "R9", "words left unsent", exp_q.size(), 0);
        check(sync_n === 1'b1 && sclk === 1'b1 && !busy, "R3", "idle levels at end",
              {sync_n, sclk, busy}, 3'b110);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule